// File: doc/BRIEF.md
# Virtual processor run/stop controller

This block sequences a cluster of virtual processors (VPs) in and out of the running state. Software controls it through memory-mapped accesses. A start register launches halted VPs. A stop register halts running VPs. A status register reports which VPs are running.

Starting a VP is a two-step action. The VP first gets a one-cycle reset pulse while it is still held halted, and on the next cycle its halt line is released. Stopping a VP raises its halt line again, and the line stays high until a later start.

The whole register set can be reached through two address windows, one for the local core and one for another core. Both windows act on the same state. When the controller leaves reset, every VP is halted. A configured start-up mask is then applied once, in the same way as a write to the start register.

Top module: `vp_run_ctrl`

## Requirements
- R1: A write to the start register (byte offset 0x08 from a window base) launches every selected VP that is neither running nor in its reset pulse. Such a VP has `vp_reset` high for exactly the one cycle after the write edge, and on the following cycle its `vp_halt` goes low.
- R2: Only write-data bits 0 to NUM_VP-1 select VPs. Bits above them have no effect on the start or stop registers.
- R3: A start bit for a VP that is already running, or that is in its reset pulse, has no effect: no second pulse and no change to its halt line.
- R4: A write to the stop register (offset 0x10) raises `vp_halt` on the cycle after the write edge for every selected VP that is running. A stop bit for a VP that is not running has no effect.
- R5: A read of the status register (offset 0x18) gives `rd_valid` high on the next cycle. `rd_data` then holds, zero-extended, the running vector from before the read edge, with bit i set when VP i is running.
- R6: The local window (base 0x0100) and the other-core window (base 0x0200) decode the three offsets in the same way and act on the same state.
- R7: These accesses are unimplemented: any access outside the six register addresses, a read of the start or stop offset, and a write to the status offset. On the next cycle `bad_access` is high for that one cycle and a read returns `rd_data` zero with `rd_valid` high. An unimplemented write changes no VP state.
- R8: `vp_halt[i]` stays high as a level for as long as VP i is not running, and that includes its reset-pulse cycle.
- R9: While `rst_n` is low, every VP is halted, no `vp_reset` is high and `rd_valid` and `bad_access` are low. On the first edge after release, START_MASK is applied as a start write.
- R10: With default parameters (NUM_VP = 1, START_MASK = 1), VP 0 is pulsed and then runs after every controller reset.
- R11: `cfg_err` is high exactly when START_MASK has a bit set at position NUM_VP or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous controller reset |
| req_valid | input | 1 | Access strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | DATA_W | Write data (bit i selects VP i) |
| rd_valid | output | 1 | Read response valid, one cycle after a read |
| rd_data | output | DATA_W | Read response data |
| bad_access | output | 1 | One-cycle flag for an unimplemented access |
| cfg_err | output | 1 | Start-up mask exceeds the VP count |
| vp_reset | output | NUM_VP | Per-VP one-cycle reset pulse |
| vp_halt | output | NUM_VP | Per-VP halt level |

## Verification
Start writes are applied with patterns that mix halted, already running and out-of-range bits, so one write shows that only the halted VPs are launched. A start to a VP in its reset-pulse cycle shows that the in-flight launch is protected. Stop writes are repeated so that the second one hits only halted VPs, which shows that stop is a clear request and not a plain store. The same sequence is split across the two windows. A controller reset in mid-run shows that the start-up mask is reapplied from a cleared state.

// File: rtl/vp_ctrl_pkg.sv
package vp_ctrl_pkg;
   typedef enum logic [2:0] {
      ACC_NONE = 3'd0,
      ACC_RUN  = 3'd1,
      ACC_STOP = 3'd2,
      ACC_STAT = 3'd3,
      ACC_BAD  = 3'd4
   } acc_kind_e;

   localparam int unsigned NUM_WIN = 2;
endpackage

// File: rtl/vp_addr_dec.sv
module vp_addr_dec
   import vp_ctrl_pkg::*;
#(
   parameter int unsigned           ADDR_W   = 16,
   parameter logic [ADDR_W-1:0]     BASE_LOC = 16'h0100,
   parameter logic [ADDR_W-1:0]     BASE_OTH = 16'h0200,
   parameter logic [ADDR_W-1:0]     OFS_RUN  = 16'h0008,
   parameter logic [ADDR_W-1:0]     OFS_STOP = 16'h0010,
   parameter logic [ADDR_W-1:0]     OFS_STAT = 16'h0018
) (
   input  logic              valid,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind
);
   logic [NUM_WIN-1:0] hit_run, hit_stop, hit_stat;

   // one identical decoder slice per aliased window
   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [ADDR_W-1:0] BASE = (w == 0) ? BASE_LOC : BASE_OTH;
      localparam logic [ADDR_W-1:0] A_RUN  = BASE + OFS_RUN;
      localparam logic [ADDR_W-1:0] A_STOP = BASE + OFS_STOP;
      localparam logic [ADDR_W-1:0] A_STAT = BASE + OFS_STAT;
      assign hit_run[w]  = (addr == A_RUN);
      assign hit_stop[w] = (addr == A_STOP);
      assign hit_stat[w] = (addr == A_STAT);
   end

   always_comb begin
      kind = ACC_NONE;
      if (valid) begin
         if (write) begin
            if (|hit_run)       kind = ACC_RUN;
            else if (|hit_stop) kind = ACC_STOP;
            else                kind = ACC_BAD;
         end else begin
            if (|hit_stat)      kind = ACC_STAT;
            else                kind = ACC_BAD;
         end
      end
   end
endmodule

// File: rtl/vp_slice.sv
module vp_slice (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic stop_req,
   output logic running,
   output logic rst_pulse
);
   logic launch, retire;

   // a start only touches a VP that is idle and not already launching
   assign launch = start_req & ~running & ~rst_pulse;
   // a stop only touches a VP that is running
   assign retire = stop_req & running;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running   <= 1'b0;
         rst_pulse <= 1'b0;
      end else begin
         rst_pulse <= launch;
         if (rst_pulse)   running <= 1'b1;
         else if (retire) running <= 1'b0;
      end
   end
endmodule

// File: rtl/vp_run_ctrl.sv
module vp_run_ctrl
   import vp_ctrl_pkg::*;
#(
   parameter int unsigned       NUM_VP     = 1,
   parameter logic [63:0]       START_MASK = 64'h1,
   parameter int unsigned       DATA_W     = 64,
   parameter int unsigned       ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] BASE_LOC   = 16'h0100,
   parameter logic [ADDR_W-1:0] BASE_OTH   = 16'h0200,
   parameter logic [ADDR_W-1:0] OFS_RUN    = 16'h0008,
   parameter logic [ADDR_W-1:0] OFS_STOP   = 16'h0010,
   parameter logic [ADDR_W-1:0] OFS_STAT   = 16'h0018
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              bad_access,
   output logic              cfg_err,
   output logic [NUM_VP-1:0] vp_reset,
   output logic [NUM_VP-1:0] vp_halt
);
   localparam logic CFG_BAD = (START_MASK >> NUM_VP) != 64'd0;
   localparam logic [NUM_VP-1:0] BOOT_VEC = START_MASK[NUM_VP-1:0];

   if (NUM_VP < 1 || NUM_VP > DATA_W || DATA_W > 64) begin : g_bad_width
      $error("vp_run_ctrl: NUM_VP must be 1..DATA_W and DATA_W at most 64");
   end
   if (BASE_LOC == BASE_OTH) begin : g_bad_win
      $error("vp_run_ctrl: the two register windows must differ");
   end

   assign cfg_err = CFG_BAD;

   acc_kind_e          kind;
   logic               boot_q;
   logic [NUM_VP-1:0]  wr_vec, start_vec, stop_vec, running;

   vp_addr_dec #(
      .ADDR_W(ADDR_W), .BASE_LOC(BASE_LOC), .BASE_OTH(BASE_OTH),
      .OFS_RUN(OFS_RUN), .OFS_STOP(OFS_STOP), .OFS_STAT(OFS_STAT)
   ) u_dec (
      .valid(req_valid), .write(req_write), .addr(req_addr), .kind(kind)
   );

   // start-up: the cycle after reset release behaves as a start write
   always_ff @(posedge clk) begin
      if (!rst_n) boot_q <= 1'b1;
      else        boot_q <= 1'b0;
   end

   assign wr_vec    = req_wdata[NUM_VP-1:0];
   assign start_vec = ((kind == ACC_RUN) ? wr_vec : '0) | (boot_q ? BOOT_VEC : '0);
   assign stop_vec  = (kind == ACC_STOP) ? wr_vec : '0;

   if (NUM_VP < DATA_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^req_wdata[DATA_W-1:NUM_VP];
   end

   for (genvar i = 0; i < NUM_VP; i++) begin : g_vp
      vp_slice u_slice (
         .clk(clk), .rst_n(rst_n),
         .start_req(start_vec[i]), .stop_req(stop_vec[i]),
         .running(running[i]), .rst_pulse(vp_reset[i])
      );
      assign vp_halt[i] = ~running[i];
   end

   // registered read / error response
   logic [DATA_W-1:0] stat_word;
   always_comb begin
      stat_word = '0;
      stat_word[NUM_VP-1:0] = running;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid   <= 1'b0;
         rd_data    <= '0;
         bad_access <= 1'b0;
      end else begin
         rd_valid   <= req_valid & ~req_write;
         rd_data    <= (kind == ACC_STAT) ? stat_word : '0;
         bad_access <= (kind == ACC_BAD);
      end
   end
endmodule

// File: rtl/vp_run_ctrl_chk.sv
module vp_run_ctrl_chk #(
   parameter int unsigned NUM_VP = 1,
   parameter int unsigned DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              bad_access,
   input logic [NUM_VP-1:0] vp_reset,
   input logic [NUM_VP-1:0] vp_halt
);
   assert_pulse_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (vp_reset & $past(vp_reset)) == '0);

   assert_release_after_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(vp_reset) & vp_halt) == '0);

   assert_halt_during_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vp_reset & ~vp_halt) == '0);

   assert_status_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !bad_access) |-> (rd_data[NUM_VP-1:0] == ~$past(vp_halt)));

   assert_bad_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && bad_access) |-> (rd_data == '0));

   assert_bad_follows_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |-> $past(req_valid));

   assert_rdvalid_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(req_valid && !req_write));

   assert_reset_quiet_R9: assert property (@(posedge clk)
      !rst_n |=> (!rd_valid && !bad_access && vp_reset == '0) || rst_n);
endmodule

bind vp_run_ctrl vp_run_ctrl_chk #(.NUM_VP(NUM_VP), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .rd_valid(rd_valid), .rd_data(rd_data), .bad_access(bad_access),
   .vp_reset(vp_reset), .vp_halt(vp_halt)
);

// File: tb/sim_vp_run_ctrl.sv
`timescale 1ns/1ps
module sim_vp_run_ctrl;
   localparam int NV = 4;
   localparam logic [63:0] SM = 64'h5;
   localparam logic [15:0] L_RUN = 16'h0108, L_STOP = 16'h0110, L_STAT = 16'h0118;
   localparam logic [15:0] O_RUN = 16'h0208, O_STOP = 16'h0210, O_STAT = 16'h0218;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic rd_valid, bad_access, cfg_err;
   logic [63:0] rd_data;
   logic [NV-1:0] vp_reset, vp_halt;

   always #10 clk = ~clk;

   vp_run_ctrl #(.NUM_VP(NV), .START_MASK(SM)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
      .rd_data(rd_data), .bad_access(bad_access), .cfg_err(cfg_err),
      .vp_reset(vp_reset), .vp_halt(vp_halt));

   // default-parameter instance (R10)
   logic d_rdv, d_bad, d_cfg;
   logic [63:0] d_rdata;
   logic [0:0] d_rst, d_halt;
   vp_run_ctrl u1 (
      .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_write(1'b0),
      .req_addr(16'h0), .req_wdata(64'h0), .rd_valid(d_rdv), .rd_data(d_rdata),
      .bad_access(d_bad), .cfg_err(d_cfg), .vp_reset(d_rst), .vp_halt(d_halt));

   // invalid start-up mask instance (R11)
   logic e_rdv, e_bad, e_cfg;
   logic [63:0] e_rdata;
   logic [1:0] e_rst, e_halt;
   vp_run_ctrl #(.NUM_VP(2), .START_MASK(64'h6)) u2 (
      .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_write(1'b0),
      .req_addr(16'h0), .req_wdata(64'h0), .rd_valid(e_rdv), .rd_data(e_rdata),
      .bad_access(e_bad), .cfg_err(e_cfg), .vp_reset(e_rst), .vp_halt(e_halt));

   int n_vec = 0, n_bad = 0;

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model, advanced on every rising edge
   bit m_run[NV], m_pulse[NV];
   bit m_boot = 1'b0, m_rdv = 1'b0, m_bad = 1'b0, cmp_on = 1'b0;
   logic [63:0] m_rdata = '0;

   always @(posedge clk) begin
      bit nr[NV], np[NV];
      bit is_run, is_stop, is_stat;
      if (!rst_n) begin
         foreach (m_run[i]) begin m_run[i] = 0; m_pulse[i] = 0; end
         m_boot = 1; m_rdv = 0; m_bad = 0; m_rdata = '0;
      end else begin
         is_run  = req_valid && req_write && (req_addr == L_RUN || req_addr == O_RUN);
         is_stop = req_valid && req_write && (req_addr == L_STOP || req_addr == O_STOP);
         is_stat = req_valid && !req_write && (req_addr == L_STAT || req_addr == O_STAT);
         for (int i = 0; i < NV; i++) begin
            nr[i] = m_run[i] || m_pulse[i];
            np[i] = 0;
            if (((is_run && req_wdata[i]) || (m_boot && SM[i])) && !m_run[i] && !m_pulse[i])
               np[i] = 1;
            if (is_stop && req_wdata[i] && m_run[i]) nr[i] = 0;
         end
         m_rdv = req_valid && !req_write;
         m_rdata = '0;
         if (is_stat) for (int i = 0; i < NV; i++) m_rdata[i] = m_run[i];
         m_bad = req_valid && !(is_run || is_stop || is_stat);
         for (int i = 0; i < NV; i++) begin m_run[i] = nr[i]; m_pulse[i] = np[i]; end
         m_boot = 0;
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         logic [63:0] er, eh;
         er = '0; eh = '0;
         for (int i = 0; i < NV; i++) begin er[i] = m_pulse[i]; eh[i] = !m_run[i]; end
         chk(64'(vp_reset), er, "R1 vp_reset model");
         chk(64'(vp_halt), eh, "R8 vp_halt model");
         chk(64'(rd_valid), 64'(m_rdv), "R5 rd_valid model");
         chk(rd_data, m_rdata, "R5 rd_data model");
         chk(64'(bad_access), 64'(m_bad), "R7 bad_access model");
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic acc(input logic wr, input logic [15:0] a, input logic [63:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
   endtask

   initial begin
      #(20ns * 100000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      tick(2);
      cmp_on = 1'b1;
      tick(1);
      // R9 reset state
      chk(64'(vp_halt), 64'hF, "R9 halt in reset");
      chk(64'(vp_reset), 64'h0, "R9 no pulse in reset");
      chk(64'(d_halt), 64'h1, "R10 default halt in reset");
      chk(64'(cfg_err), 64'h0, "R11 cfg_err valid mask");
      chk(64'(d_cfg), 64'h0, "R11 cfg_err default");
      chk(64'(e_cfg), 64'h1, "R11 cfg_err mask beyond VP count");
      rst_n = 1'b1;
      tick(1);
      chk(64'(vp_reset), 64'h5, "R9 start-up mask pulse");
      chk(64'(d_rst), 64'h1, "R10 default VP0 pulse");
      chk(64'(vp_halt), 64'hF, "R8 halted during pulse");
      tick(1);
      chk(64'(vp_halt), 64'hA, "R9 start-up VPs run");
      chk(64'(d_halt), 64'h0, "R10 default VP0 runs");
      acc(1'b0, L_STAT, '0);
      chk(rd_data, 64'h5, "R5 status read");
      // bit0 already running (R3), high bits ignored (R2)
      acc(1'b1, L_RUN, 64'hFFFF_FFFF_FFFF_FFF3);
      chk(64'(vp_reset), 64'h2, "R1 R2 R3 only halted selected VP pulsed");
      tick(1);
      chk(64'(vp_halt), 64'h8, "R1 release after pulse");
      acc(1'b1, O_RUN, 64'h8);
      chk(64'(vp_reset), 64'h8, "R6 start via other window");
      tick(1);
      acc(1'b1, O_STOP, 64'hF0 | 64'h3);
      chk(64'(vp_halt), 64'h3, "R4 R6 stop via other window");
      acc(1'b1, L_STOP, 64'h3);
      chk(64'(vp_halt), 64'h3, "R4 stop of halted VPs no effect");
      acc(1'b0, O_STAT, '0);
      chk(rd_data, 64'hC, "R6 status via other window");
      acc(1'b0, L_RUN, '0);
      chk(64'(bad_access), 64'h1, "R7 read of start offset flagged");
      chk(rd_data, 64'h0, "R7 bad read returns zero");
      acc(1'b1, L_STAT, 64'hF);
      chk(64'(bad_access), 64'h1, "R7 write to status flagged");
      chk(64'(vp_reset), 64'h0, "R7 write to status no pulse");
      tick(1);
      chk(64'(bad_access), 64'h0, "R7 flag lasts one cycle");
      acc(1'b1, 16'h0300, 64'hF);
      chk(64'(vp_reset), 64'h0, "R7 unmapped write ignored");
      tick(1);
      chk(64'(vp_halt), 64'h3, "R7 unmapped write leaves state");
      // back-to-back start of the same VP (R3)
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = L_RUN; req_wdata = 64'h1;
      @(negedge clk);
      chk(64'(vp_reset), 64'h1, "R1 first start pulses");
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
      chk(64'(vp_reset), 64'h0, "R3 start during pulse ignored");
      chk(64'(vp_halt), 64'h2, "R1 VP0 released");
      tick(2);
      // controller reset in mid-run
      rst_n = 1'b0;
      tick(2);
      chk(64'(vp_halt), 64'hF, "R9 all halted in reset");
      rst_n = 1'b1;
      tick(1);
      chk(64'(vp_reset), 64'h5, "R9 start-up mask reapplied");
      tick(2);
      chk(64'(vp_halt), 64'hA, "R9 start-up VPs run again");
      chk(64'(d_halt), 64'h0, "R10 default VP0 runs again");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule